// File: doc/BRIEF.md
# Paired-Word Load/Store Execution Unit

This unit carries out the 64-bit paired-register memory instructions of a 32-bit processor pipeline. When `start_i` is pulsed it captures the instruction word together with the base value, the offset-register value and the two source values. These values come from the register-file read ports. In the same cycle it decides whether the encoding is legal and whether the computed address is aligned to 8 bytes.

A legal, aligned instruction then moves an even/odd register pair as two 32-bit memory beats over a request/ready interface. The first beat covers the lower register at the effective address, and the second covers the upper register at that address plus 4. Each beat holds its request until the memory accepts it. A beat may report an abort. In that case the unit stops and commits nothing.

After both beats succeed, the unit spends one commit cycle. In that cycle it presents the writes to the data pair (for a load) and the base-register update, together with `done_o`. An illegal encoding ends the operation at once with `undef_o`. A misaligned address ends it with `dabort_o`, and no memory traffic takes place.

Top module: `pair_ldst_unit`

## Requirements
- R1: Instruction bits [7:4] select the operation: 4'hD is a pair load and 4'hE is a pair store; any other value ends the start with a one-cycle `undef_o` and no memory request.
- R2: Bit 21 (writeback) set while bit 24 (pre-index) is clear ends the start with `undef_o`, no memory request and no register write.
- R3: The data register number is instr[15:12] and the base register number is instr[19:16]. A load whose data register is odd or equal to 14 is undefined. A store whose data register is odd, or whose base register is 15, is undefined. A load with base 15 is legal.
- R4: The offset is {instr[11:8], instr[3:0]} zero-extended when bit 22 is set, else `offs_val_i`. Bit 23 set adds the offset to `base_val_i` and clear subtracts it. The effective address is that sum when bit 24 is set, else the unmodified base.
- R5: An effective address with any of bits [2:0] set ends the start with a one-cycle `dabort_o` and no memory request. This check comes after the R1, R2 and R3 checks and before the R6 check.
- R6: When bit 24 is clear or bit 21 is set, a base register equal to the data register or to the data register plus one is undefined.
- R7: Beat one drives the effective address (store data `src_lo_i`); beat two drives address+4 (store data `src_hi_i`). `mem_we_o` is 1 for a store. Each request holds address, direction and data stable until `mem_ready_i`.
- R8: `mem_abort_i` sampled with `mem_ready_i` on either beat raises `dabort_o` one cycle later. It makes no register or base write, and an abort on beat one suppresses beat two.
- R9: On success a single cycle shows `done_o`. A load writes beat-one data to register Rt and beat-two data to Rt+1. The base register is written with base±offset exactly when bit 24 is clear or bit 21 is set.
- R10: `done_o` appears 1 cycle after the second beat's accepting edge for a store and 3 cycles after it for a load (two internal cycles).
- R11: Out of reset all outputs are idle. An accepted legal, aligned start keeps `busy_o` high from the next cycle through the `done_o` cycle. `undef_o` and `dabort_o` appear with `busy_o` low. A `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| instr_i | input | 32 | Instruction word |
| base_val_i | input | 32 | Value of the base register |
| offs_val_i | input | 32 | Value of the offset register named in instr[3:0] |
| src_lo_i | input | 32 | Value of data register Rt (store) |
| src_hi_i | input | 32 | Value of data register Rt+1 (store) |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| mem_abort_i | input | 1 | Current beat faulted (valid with ready) |
| mem_rdata_i | input | 32 | Read data (valid with ready) |
| mem_req_o | output | 1 | Beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 32 | Beat write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Commit cycle, operation complete |
| undef_o | output | 1 | Undefined-instruction pulse |
| dabort_o | output | 1 | Alignment or memory abort pulse |
| rf_we_lo_o | output | 1 | Write Rt |
| rf_waddr_lo_o | output | 4 | Register number Rt |
| rf_wdata_lo_o | output | 32 | Data for Rt |
| rf_we_hi_o | output | 1 | Write Rt+1 |
| rf_waddr_hi_o | output | 4 | Register number Rt+1 |
| rf_wdata_hi_o | output | 32 | Data for Rt+1 |
| base_we_o | output | 1 | Write back the base register |
| base_waddr_o | output | 4 | Base register number |
| base_wdata_o | output | 32 | Updated base value |

## Verification
A new `start_i` can arrive in the very cycle in which a beat handshake completes, so decode of a fresh instruction and progress of the running one fall on the same clock edge. The bench provokes this by holding `start_i` high for a second cycle with an illegal word on `instr_i`, while the random ready delay lets the first beat be accepted on that edge. It then judges that the outcome, beat addresses and commit writes still match the original instruction and that no `undef_o` appears. Random ready stalls also place request holds next to handshakes, and these are checked beat by beat against bench-computed addresses and data.

// File: rtl/pair_ldst_pkg.sv
package pair_ldst_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned RIDX_W = 4;
  localparam logic [3:0]  OP_PAIR_LOAD  = 4'hD;
  localparam logic [3:0]  OP_PAIR_STORE = 4'hE;
  localparam logic [RIDX_W-1:0] IDX_PC = 4'd15;
  localparam logic [RIDX_W-1:0] IDX_LR = 4'd14;

  typedef enum logic [1:0] {
    VERD_GO    = 2'd0,
    VERD_UNDEF = 2'd1,
    VERD_ALIGN = 2'd2
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BEAT0  = 3'd1,
    ST_BEAT1  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_COMMIT = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic              is_load;
    logic              base_wb;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
    logic [WORD_W-1:0] ea;
    logic [WORD_W-1:0] sum;
  } pair_req_t;

endpackage

// File: rtl/pair_rst_sync.sv
module pair_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pair_decode.sv
module pair_decode
  import pair_ldst_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 3
) (
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] base_val_i,
  input  logic [WORD_W-1:0] offs_val_i,
  output verdict_e          verdict_o,
  output pair_req_t         req_o
);
  logic              op_load, op_store;
  logic              f_wb, f_imm, f_up, f_pre;
  logic [RIDX_W-1:0] rn, rt, rt_hi;
  logic [WORD_W-1:0] offset, sum, ea;
  logic              base_wb, overlap, misaligned, bad_pair;
  logic              unused_fields;

  assign op_load  = (instr_i[7:4] == OP_PAIR_LOAD);
  assign op_store = (instr_i[7:4] == OP_PAIR_STORE);
  assign f_wb     = instr_i[21];
  assign f_imm    = instr_i[22];
  assign f_up     = instr_i[23];
  assign f_pre    = instr_i[24];
  assign rn       = instr_i[19:16];
  assign rt       = instr_i[15:12];
  assign rt_hi    = rt + RIDX_W'(1);
  assign unused_fields = ^{instr_i[31:25], instr_i[20]};

  // Address generation
  assign offset  = f_imm ? {{(WORD_W-8){1'b0}}, instr_i[11:8], instr_i[3:0]} : offs_val_i;
  assign sum     = f_up ? (base_val_i + offset) : (base_val_i - offset);
  assign ea      = f_pre ? sum : base_val_i;
  assign base_wb = !f_pre || f_wb;

  assign misaligned = |ea[ALIGN_BITS-1:0];
  assign overlap    = base_wb && ((rn == rt) || (rn == rt_hi));
  assign bad_pair   = rt[0] || (op_load && (rt == IDX_LR));

  // Legality, in priority order
  always_comb begin
    if (!op_load && !op_store)        verdict_o = VERD_UNDEF;
    else if (f_wb && !f_pre)          verdict_o = VERD_UNDEF;
    else if (op_store && rn == IDX_PC) verdict_o = VERD_UNDEF;
    else if (bad_pair)                verdict_o = VERD_UNDEF;
    else if (misaligned)              verdict_o = VERD_ALIGN;
    else if (overlap)                 verdict_o = VERD_UNDEF;
    else                              verdict_o = VERD_GO;
  end

  assign req_o = '{is_load: op_load, base_wb: base_wb, rn: rn, rt: rt, ea: ea, sum: sum};
endmodule

// File: rtl/pair_beat_seq.sv
module pair_beat_seq
  import pair_ldst_pkg::*;
#(
  parameter int unsigned ALIGN_BITS       = 3,
  parameter int unsigned LOAD_TAIL_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  verdict_e          verdict_i,
  input  pair_req_t         req_i,
  input  logic [WORD_W-1:0] src_lo_i,
  input  logic [WORD_W-1:0] src_hi_i,
  input  logic              mem_ready_i,
  input  logic              mem_abort_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              undef_o,
  output logic              dabort_o,
  output logic              commit_o,
  output pair_req_t         req_o,
  output logic [WORD_W-1:0] data_lo_o,
  output logic [WORD_W-1:0] data_hi_o
);
  localparam bit          HAS_TAIL = (LOAD_TAIL_CYCLES > 0);
  localparam int unsigned CNT_W    = (LOAD_TAIL_CYCLES > 1) ? $clog2(LOAD_TAIL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TAIL_LAST =
    CNT_W'((LOAD_TAIL_CYCLES > 0) ? (LOAD_TAIL_CYCLES - 1) : 0);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              undef_q, undef_d, dabort_q, dabort_d;
  pair_req_t         req_q;
  logic [WORD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              req_en, lo_en, hi_en;
  seq_state_e        after_last;

  assign after_last = (req_q.is_load && HAS_TAIL) ? ST_HOLD : ST_COMMIT;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    undef_d  = 1'b0;
    dabort_d = 1'b0;
    req_en   = 1'b0;
    lo_en    = 1'b0;
    hi_en    = 1'b0;
    lo_d     = lo_q;
    hi_d     = hi_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          unique case (verdict_i)
            VERD_GO: begin
              state_d = ST_BEAT0;
              req_en  = 1'b1;
              lo_en   = 1'b1;
              hi_en   = 1'b1;
              lo_d    = src_lo_i;
              hi_d    = src_hi_i;
            end
            VERD_UNDEF: undef_d  = 1'b1;
            default:    dabort_d = 1'b1;
          endcase
        end
      end
      ST_BEAT0: begin
        if (mem_ready_i) begin
          if (mem_abort_i) begin
            state_d  = ST_IDLE;
            dabort_d = 1'b1;
          end else begin
            state_d = ST_BEAT1;
            lo_en   = req_q.is_load;
            lo_d    = mem_rdata_i;
          end
        end
      end
      ST_BEAT1: begin
        if (mem_ready_i) begin
          if (mem_abort_i) begin
            state_d  = ST_IDLE;
            dabort_d = 1'b1;
          end else begin
            state_d = after_last;
            cnt_d   = '0;
            hi_en   = req_q.is_load;
            hi_d    = mem_rdata_i;
          end
        end
      end
      ST_HOLD: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == TAIL_LAST) state_d = ST_COMMIT;
      end
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      undef_q  <= 1'b0;
      dabort_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      undef_q  <= undef_d;
      dabort_q <= dabort_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (req_en) req_q <= req_i;
    if (lo_en)  lo_q  <= lo_d;
    if (hi_en)  hi_q  <= hi_d;
  end

  assign mem_req_o   = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign mem_we_o    = !req_q.is_load;
  assign mem_addr_o  = (state_q == ST_BEAT1) ? (req_q.ea + WORD_W'(4)) : req_q.ea;
  assign mem_wdata_o = (state_q == ST_BEAT1) ? hi_q : lo_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign undef_o     = undef_q;
  assign dabort_o    = dabort_q;
  assign commit_o    = (state_q == ST_COMMIT);
  assign req_o       = req_q;
  assign data_lo_o   = lo_q;
  assign data_hi_o   = hi_q;

  // R7: a stalled request keeps its beat unchanged
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R7: second beat sits four bytes above the first
  a_r7_second_beat_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BEAT1 && $past(state_q) == ST_BEAT0)
      |-> (mem_addr_o == $past(mem_addr_o) + WORD_W'(4)));

  // R5: no beat is ever issued to a misaligned pair address
  a_r5_aligned_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BEAT0) |-> (mem_addr_o[ALIGN_BITS-1:0] == '0));

  // R11: an idle start always produces busy or an immediate outcome
  a_r11_start_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o || undef_o || dabort_o));

  // R11: outcomes are mutually exclusive
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_o, dabort_o, commit_o}));
endmodule

// File: rtl/pair_commit.sv
module pair_commit
  import pair_ldst_pkg::*;
(
  input  logic              commit_i,
  input  pair_req_t         req_i,
  input  logic [WORD_W-1:0] data_lo_i,
  input  logic [WORD_W-1:0] data_hi_i,
  output logic              done_o,
  output logic              rf_we_lo_o,
  output logic [RIDX_W-1:0] rf_waddr_lo_o,
  output logic [WORD_W-1:0] rf_wdata_lo_o,
  output logic              rf_we_hi_o,
  output logic [RIDX_W-1:0] rf_waddr_hi_o,
  output logic [WORD_W-1:0] rf_wdata_hi_o,
  output logic              base_we_o,
  output logic [RIDX_W-1:0] base_waddr_o,
  output logic [WORD_W-1:0] base_wdata_o
);
  logic unused_ea;
  assign unused_ea = ^req_i.ea;

  assign done_o        = commit_i;
  assign rf_we_lo_o    = commit_i && req_i.is_load;
  assign rf_we_hi_o    = commit_i && req_i.is_load;
  assign rf_waddr_lo_o = req_i.rt;
  assign rf_waddr_hi_o = req_i.rt + RIDX_W'(1);
  assign rf_wdata_lo_o = data_lo_i;
  assign rf_wdata_hi_o = data_hi_i;
  assign base_we_o     = commit_i && req_i.base_wb;
  assign base_waddr_o  = req_i.rn;
  assign base_wdata_o  = req_i.sum;
endmodule

// File: rtl/pair_ldst_unit.sv
module pair_ldst_unit
  import pair_ldst_pkg::*;
#(
  parameter int unsigned ALIGN_BITS       = 3,
  parameter int unsigned LOAD_TAIL_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] base_val_i,
  input  logic [31:0] offs_val_i,
  input  logic [31:0] src_lo_i,
  input  logic [31:0] src_hi_i,
  input  logic        mem_ready_i,
  input  logic        mem_abort_i,
  input  logic [31:0] mem_rdata_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        undef_o,
  output logic        dabort_o,
  output logic        rf_we_lo_o,
  output logic [3:0]  rf_waddr_lo_o,
  output logic [31:0] rf_wdata_lo_o,
  output logic        rf_we_hi_o,
  output logic [3:0]  rf_waddr_hi_o,
  output logic [31:0] rf_wdata_hi_o,
  output logic        base_we_o,
  output logic [3:0]  base_waddr_o,
  output logic [31:0] base_wdata_o
);
  logic              rst_q_n;
  verdict_e          verdict;
  pair_req_t         dec_req, held_req;
  logic              commit;
  logic [WORD_W-1:0] data_lo, data_hi;

  pair_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q_n));

  pair_decode #(.ALIGN_BITS(ALIGN_BITS)) u_dec (
    .instr_i(instr_i), .base_val_i(base_val_i), .offs_val_i(offs_val_i),
    .verdict_o(verdict), .req_o(dec_req)
  );

  pair_beat_seq #(.ALIGN_BITS(ALIGN_BITS), .LOAD_TAIL_CYCLES(LOAD_TAIL_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .start_i(start_i), .verdict_i(verdict), .req_i(dec_req),
    .src_lo_i(src_lo_i), .src_hi_i(src_hi_i),
    .mem_ready_i(mem_ready_i), .mem_abort_i(mem_abort_i), .mem_rdata_i(mem_rdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .undef_o(undef_o), .dabort_o(dabort_o),
    .commit_o(commit), .req_o(held_req), .data_lo_o(data_lo), .data_hi_o(data_hi)
  );

  pair_commit u_commit (
    .commit_i(commit), .req_i(held_req), .data_lo_i(data_lo), .data_hi_i(data_hi),
    .done_o(done_o),
    .rf_we_lo_o(rf_we_lo_o), .rf_waddr_lo_o(rf_waddr_lo_o), .rf_wdata_lo_o(rf_wdata_lo_o),
    .rf_we_hi_o(rf_we_hi_o), .rf_waddr_hi_o(rf_waddr_hi_o), .rf_wdata_hi_o(rf_wdata_hi_o),
    .base_we_o(base_we_o), .base_waddr_o(base_waddr_o), .base_wdata_o(base_wdata_o)
  );

  // R8: a faulted operation never writes registers
  a_r8_no_write_on_abort: assert property (@(posedge clk) disable iff (!rst_q_n)
    dabort_o |-> (!rf_we_lo_o && !rf_we_hi_o && !base_we_o));

  // R9: register and base writes only in the done cycle
  a_r9_writes_in_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rf_we_lo_o || rf_we_hi_o || base_we_o) |-> (done_o && busy_o));

  // R11: undefined outcome leaves the unit idle
  a_r11_undef_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    undef_o |-> (!busy_o && !mem_req_o));
endmodule

// File: tb/test_pair_ldst_unit.sv
module test_pair_ldst_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mem_ready_i, mem_abort_i;
  logic [31:0] instr_i, base_val_i, offs_val_i, src_lo_i, src_hi_i, mem_rdata_i;
  logic        mem_req_o, mem_we_o, busy_o, done_o, undef_o, dabort_o;
  logic [31:0] mem_addr_o, mem_wdata_o, rf_wdata_lo_o, rf_wdata_hi_o, base_wdata_o;
  logic        rf_we_lo_o, rf_we_hi_o, base_we_o;
  logic [3:0]  rf_waddr_lo_o, rf_waddr_hi_o, base_waddr_o;

  int n_cmp = 0;
  int n_mis = 0;

  always #10 clk = ~clk;  // 50 MHz

  pair_ldst_unit i_pair_ldst_unit (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [3:0] op, bit pre, bit up, bit imm, bit wb,
                                     logic [3:0] rn, logic [3:0] rt, logic [7:0] lo8);
    return {4'hE, 3'b000, pre, up, imm, wb, 1'b0, rn, rt, lo8[7:4], op, lo8[3:0]};
  endfunction

  // Expected outcome: 0 done, 1 undefined, 2 alignment abort
  task automatic model(input logic [31:0] ins, input logic [31:0] base, input logic [31:0] offs,
                       output int kind, output logic [31:0] ea, output logic [31:0] sum,
                       output bit wb, output string tag);
    logic [3:0]  op, rn, rt;
    logic [31:0] off;
    bit w, pre;
    op  = ins[7:4]; rn = ins[19:16]; rt = ins[15:12];
    w   = ins[21]; pre = ins[24];
    off = ins[22] ? {24'h0, ins[11:8], ins[3:0]} : offs;
    sum = ins[23] ? base + off : base - off;
    ea  = pre ? sum : base;
    wb  = !pre || w;
    if (op != 4'hD && op != 4'hE)                     begin kind = 1; tag = "R1"; end
    else if (w && !pre)                               begin kind = 1; tag = "R2"; end
    else if (op == 4'hE && rn == 4'd15)               begin kind = 1; tag = "R3"; end
    else if (rt[0] || (op == 4'hD && rt == 4'd14))    begin kind = 1; tag = "R3"; end
    else if (ea[2:0] != 3'b000)                       begin kind = 2; tag = "R5"; end
    else if (wb && (rn == rt || rn == rt + 4'd1))     begin kind = 1; tag = "R6"; end
    else                                              begin kind = 0; tag = "R9"; end
  endtask

  task automatic run_op(logic [31:0] ins, logic [31:0] base, logic [31:0] offs,
                        logic [31:0] slo, logic [31:0] shi, int abort_beat, bit glitch);
    int kind, exp_kind, exp_beats, got, got_it, hs_it, nb, waitc, lim;
    logic [31:0] ea, sum, ba[4], bd[4], rd[4];
    logic        bw[4];
    bit wb, is_load, busy_bad, busy_end;
    bit g_we_lo, g_we_hi, g_bwe;
    logic [3:0]  g_wa_lo, g_wa_hi, g_bwa;
    logic [31:0] g_wd_lo, g_wd_hi, g_bwd;
    string tag;
    model(ins, base, offs, kind, ea, sum, wb, tag);
    is_load = (ins[7:4] == 4'hD);
    exp_kind = kind; exp_beats = (kind == 0) ? 2 : 0;
    if (kind == 0 && abort_beat >= 0) begin
      exp_kind = 2; exp_beats = abort_beat + 1; tag = "R8";
    end
    @(negedge clk);
    instr_i = ins; base_val_i = base; offs_val_i = offs;
    src_lo_i = slo; src_hi_i = shi; start_i = 1'b1;
    nb = 0; waitc = 0; lim = $urandom % 3; got = -1; got_it = 0; hs_it = 0; busy_bad = 0;
    busy_end = 0; g_we_lo = 0; g_we_hi = 0; g_bwe = 0;
    g_wa_lo = 0; g_wa_hi = 0; g_bwa = 0; g_wd_lo = 0; g_wd_hi = 0; g_bwd = 0;
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      if (it == 0) begin
        if (glitch) instr_i = 32'h0;  // illegal word offered while busy
        else start_i = 1'b0;
      end else if (it == 1) start_i = 1'b0;
      mem_ready_i = 1'b0; mem_abort_i = 1'b0;
      if (done_o) got = 0; else if (undef_o) got = 1; else if (dabort_o) got = 2;
      if (got >= 0) begin
        got_it = it; busy_end = busy_o;
        g_we_lo = rf_we_lo_o; g_we_hi = rf_we_hi_o; g_bwe = base_we_o;
        g_wa_lo = rf_waddr_lo_o; g_wa_hi = rf_waddr_hi_o; g_bwa = base_waddr_o;
        g_wd_lo = rf_wdata_lo_o; g_wd_hi = rf_wdata_hi_o; g_bwd = base_wdata_o;
        break;
      end
      if (!busy_o) busy_bad = 1;
      if (mem_req_o) begin
        if (waitc >= lim) begin
          if (nb < 4) begin
            ba[nb] = mem_addr_o; bd[nb] = mem_wdata_o; bw[nb] = mem_we_o;
            rd[nb] = $urandom;
            mem_rdata_i = rd[nb];
          end
          mem_ready_i = 1'b1;
          mem_abort_i = (nb == abort_beat);
          nb++; hs_it = it; waitc = 0; lim = $urandom % 3;
        end else waitc++;
      end
    end
    start_i = 1'b0; mem_ready_i = 1'b0; mem_abort_i = 1'b0;

    chk(tag, "outcome", got, exp_kind);
    chk(tag, "beat count", nb, exp_beats);
    chk("R11", "busy while running", busy_bad, 0);
    for (int b = 0; b < nb && b < 4; b++) begin
      chk("R7", "beat address", ba[b], ea + 32'(4 * b));
      chk("R7", "beat direction", bw[b], !is_load);
      if (!is_load) chk("R7", "store data", bd[b], (b == 0) ? slo : shi);
    end
    if (got == 0) begin
      chk("R11", "busy in done cycle", busy_end, 1);
      chk("R10", "done latency", got_it - hs_it, is_load ? 3 : 1);
      chk("R9", "load write lo enable", g_we_lo, is_load);
      chk("R9", "load write hi enable", g_we_hi, is_load);
      if (is_load) begin
        chk("R9", "Rt number", g_wa_lo, ins[15:12]);
        chk("R9", "Rt+1 number", g_wa_hi, ins[15:12] + 4'd1);
        chk("R9", "Rt data", g_wd_lo, rd[0]);
        chk("R9", "Rt+1 data", g_wd_hi, rd[1]);
      end
      chk("R9", "base write enable", g_bwe, wb);
      if (wb) begin
        chk("R9", "base number", g_bwa, ins[19:16]);
        chk("R4", "base value", g_bwd, sum);
      end
    end else if (got > 0) begin
      chk(tag, "busy low at fault", busy_end, 0);
      chk(tag, "no write at fault", {g_we_lo, g_we_hi, g_bwe}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    void'($urandom(32'd20871));
    rst_n = 1'b0; start_i = 0; mem_ready_i = 0; mem_abort_i = 0;
    instr_i = 0; base_val_i = 0; offs_val_i = 0; src_lo_i = 0; src_hi_i = 0; mem_rdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "reset busy", busy_o, 0);
    chk("R11", "reset request", mem_req_o, 0);
    chk("R11", "reset outcomes", {done_o, undef_o, dabort_o}, 0);

    // Directed corners
    run_op(mk(4'hD, 1, 1, 1, 0, 4'd3, 4'd4, 8'h10), 32'h1000, 0, 0, 0, -1, 0);         // R4 pre add imm load
    run_op(mk(4'hE, 0, 0, 0, 0, 4'd5, 4'd2, 8'h07), 32'h2000, 32'h18, 32'hA5A5_0001,
           32'h5A5A_0002, -1, 0);                                                       // R4 post sub reg store
    run_op(mk(4'hD, 1, 0, 1, 1, 4'd1, 4'd6, 8'h08), 32'h3010, 0, 0, 0, -1, 0);         // R9 pre with writeback
    run_op(mk(4'hD, 0, 1, 1, 1, 4'd1, 4'd6, 8'h08), 32'h3000, 0, 0, 0, -1, 0);         // R2
    run_op(mk(4'hD, 1, 1, 1, 0, 4'd1, 4'd14, 8'h00), 32'h3000, 0, 0, 0, -1, 0);        // R3 LR
    run_op(mk(4'hE, 1, 1, 1, 0, 4'd1, 4'd3, 8'h00), 32'h3000, 0, 0, 0, -1, 0);         // R3 odd
    run_op(mk(4'hE, 1, 1, 1, 0, 4'd15, 4'd2, 8'h00), 32'h3000, 0, 0, 0, -1, 0);        // R3 store PC base
    run_op(mk(4'hD, 1, 1, 1, 0, 4'd15, 4'd2, 8'h00), 32'h3000, 0, 0, 0, -1, 0);        // R3 load PC base legal
    run_op(mk(4'hD, 1, 1, 1, 0, 4'd1, 4'd2, 8'h04), 32'h3000, 0, 0, 0, -1, 0);         // R5
    run_op(mk(4'hD, 0, 1, 1, 0, 4'd3, 4'd2, 8'h00), 32'h3002, 0, 0, 0, -1, 0);         // R5 beats R6
    run_op(mk(4'hE, 0, 1, 1, 0, 4'd3, 4'd2, 8'h08), 32'h3000, 0, 1, 2, -1, 0);         // R6 rn==Rt+1
    run_op(mk(4'hD, 1, 1, 1, 0, 4'd2, 4'd2, 8'h08), 32'h3000, 0, 0, 0, -1, 0);         // R6 not applied
    run_op(mk(4'hD, 1, 1, 1, 0, 4'd1, 4'd8, 8'h00), 32'h4000, 0, 0, 0, 0, 0);          // R8 first beat
    run_op(mk(4'hE, 0, 1, 1, 0, 4'd1, 4'd8, 8'h08), 32'h4000, 0, 7, 9, 1, 0);          // R8 second beat
    run_op(mk(4'h9, 1, 1, 1, 0, 4'd1, 4'd8, 8'h00), 32'h4000, 0, 0, 0, -1, 0);         // R1
    run_op(mk(4'hD, 0, 1, 1, 0, 4'd9, 4'd0, 8'h20), 32'h5000, 0, 0, 0, -1, 1);         // R11 start while busy
    run_op(mk(4'hE, 1, 1, 0, 1, 4'd9, 4'd0, 8'h00), 32'h5000, 32'h40, 3, 4, -1, 1);    // R11 store

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  op, rn, rt;
      logic [7:0]  lo8;
      logic [31:0] base, offs;
      int r, ab;
      r  = $urandom % 8;
      op = (r < 4) ? 4'hD : (r < 7) ? 4'hE : 4'($urandom);
      rn = 4'($urandom);
      rt = ($urandom % 4 == 0) ? 4'($urandom) : (4'($urandom) & 4'hE);
      lo8  = ($urandom % 4 == 0) ? 8'($urandom) : (8'($urandom) & 8'hF8);
      base = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFF_FFF8);
      offs = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFF_FFF8);
      r  = $urandom % 8;
      ab = (r == 0) ? 0 : (r == 1) ? 1 : -1;
      run_op(mk(op, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 == 0), rn, rt, lo8),
             base, offs, $urandom, $urandom, ab, ($urandom % 10 == 0));
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule